// File: doc/BRIEF.md
# Transaction Packet Transmit Driver

This block sits on the application side of a packet transmitter and feeds transaction layer packets into a transmit path that has two separate buses. The first is a 128-bit header bus with a request/acknowledge handshake. The second is a 64-bit data bus with a per-beat valid/ready handshake. The application hands over one packet at a time as a 3 or 4 DWORD header. If the header's format says the packet carries data, the application then supplies the payload as a stream of 32-bit DWORDs.

The driver takes three facts from the header: whether a payload follows, the header size, and the payload length. It places the header on the header bus and holds it there until it is acknowledged. It then packs the payload two DWORDs per data beat. Address bit 2 of the packet decides whether the first DWORD lands in the lower or the upper half of the first beat. That address bit sits at a different header bit for each header size.

Packets without a payload can follow one another with no idle cycle between them. A packet with a payload blocks the next header until its last beat has been taken.

Top module: `tlp_tx_driver`

## Requirements
- R1: After a synchronous reset, `hdr_req`, `beat_valid`, `beat_last` and `busy` are 0 and `pkt_ready` is 1.
- R2: When `pkt_valid` and `pkt_ready` are both 1 at a clock edge, `hdr_req` is 1 from the next cycle and `hdr_bus` equals `pkt_hdr` bit for bit. Header byte 0 is at [127:120] and byte 15 is at [7:0].
- R3: While `hdr_req` is 1 and `hdr_ack` is 0, both `hdr_req` and `hdr_bus` keep their values into the next cycle.
- R4: A header whose bit 126 is 0 has no payload, and its packet completes at the acknowledge. In that acknowledge cycle `pkt_ready` is 1, so a new header given then appears on `hdr_bus` in the next cycle while `hdr_req` stays 1.
- R5: No data beat is presented and no payload DWORD is taken before the header has been acknowledged.
- R6: The payload length in DWORDs is header bits [105:96], where a value of 0 means 1024.
- R7: When header bit 125 is 1 (4 DWORD header), header bit 2 picks the alignment: 0 puts the first DWORD on `beat_data[31:0]` and 1 puts it on `beat_data[63:32]`. Bit 34 is ignored in this case.
- R8: When header bit 125 is 0 (3 DWORD header), header bit 34 picks the alignment in the same way. Bit 2 is ignored in this case.
- R9: Payload DWORDs fill the beats in arrival order, lower half before upper half. When the first DWORD is upper-aligned, the lower half of the first beat is 0.
- R10: `beat_last` is 1 on exactly the final beat of a payload. When the final DWORD lands in the lower half, the upper half of that beat is 0.
- R11: While `beat_valid` is 1 and `beat_ready` is 0, `beat_valid`, `beat_data` and `beat_last` keep their values.
- R12: `busy` is 1 from the cycle after a packet is accepted until the packet completes. When the final beat is taken, `busy` drops in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_valid | input | 1 | Application offers a packet header |
| pkt_hdr | input | 128 | Packet header, byte 0 in the top byte |
| pkt_ready | output | 1 | Driver accepts the offered header this cycle |
| pay_valid | input | 1 | Payload DWORD available |
| pay_dw | input | 32 | Payload DWORD |
| pay_ready | output | 1 | Driver takes the payload DWORD this cycle |
| hdr_req | output | 1 | Header bus request |
| hdr_bus | output | 128 | Header bus |
| hdr_ack | input | 1 | Header bus acknowledge |
| beat_valid | output | 1 | Data beat valid |
| beat_data | output | 64 | Data beat |
| beat_last | output | 1 | Final beat of the payload |
| beat_ready | input | 1 | Data bus accepts the beat |
| busy | output | 1 | A packet is in progress |

## Verification
The bench drives headers whose unused alignment bit is always the opposite of the bit that counts. A design that reads bit 2 for a 3 DWORD header, or bit 34 for a 4 DWORD header, therefore shifts every payload DWORD by one half and fails the beat compares.

It covers several payload shapes:
- a single upper-aligned DWORD;
- odd and even lengths with both alignments;
- a length field of 0, which must produce 512 beats and not a single one or none;
- stalls on `beat_ready`, which catch a driver that drops or replaces a held beat.

Back-to-back headers with no payload test that a new header follows the acknowledge in the very next cycle with the request held high. A driver that drops the request or loses the second header fails there.

// File: rtl/tlp_tx_pkg.sv
package tlp_tx_pkg;
  localparam int TLP_LEN_W = 10;
  localparam int TLP_CNT_W = TLP_LEN_W + 1;

  typedef enum logic [1:0] {ST_IDLE, ST_HDR, ST_DATA} tx_state_e;

  typedef struct packed {
    logic                 has_data;
    logic                 four_dw;
    logic                 align_hi;
    logic [TLP_CNT_W-1:0] dw_count;
  } hdr_info_t;
endpackage

// File: rtl/tlp_hdr_decode.sv
module tlp_hdr_decode
  import tlp_tx_pkg::*;
(
  input  logic                 fmt_data,
  input  logic                 fmt_4dw,
  input  logic [TLP_LEN_W-1:0] len_field,
  input  logic                 addr2_4dw,
  input  logic                 addr2_3dw,
  output hdr_info_t            info
);
  localparam logic [TLP_CNT_W-1:0] MAX_DW = TLP_CNT_W'(1) << TLP_LEN_W;

  always_comb begin
    info.has_data = fmt_data;
    info.four_dw  = fmt_4dw;
    info.align_hi = fmt_4dw ? addr2_4dw : addr2_3dw;
    info.dw_count = (len_field == '0) ? MAX_DW : {1'b0, len_field};
  end
endmodule

// File: rtl/tlp_hdr_stage.sv
module tlp_hdr_stage #(
  parameter int HDR_W = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [HDR_W-1:0] load_hdr,
  input  logic             ack,
  output logic             req,
  output logic [HDR_W-1:0] bus
);
  always_ff @(posedge clk) begin
    if (rst) begin
      req <= 1'b0;
      bus <= '0;
    end else if (load) begin
      req <= 1'b1;
      bus <= load_hdr;
    end else if (req && ack) begin
      req <= 1'b0;
    end
  end

  // R3: header held stable until acknowledged
  p_hdr_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (req && !ack) |=> (req && $stable(bus)));
endmodule

// File: rtl/tlp_data_packer.sv
module tlp_data_packer
  import tlp_tx_pkg::*;
#(
  parameter int DW_W = 32,
  localparam int BEAT_W = 2 * DW_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic                 start_align,
  input  logic [TLP_CNT_W-1:0] start_count,
  input  logic                 pay_valid,
  input  logic [DW_W-1:0]      pay_dw,
  output logic                 pay_ready,
  output logic                 beat_valid,
  output logic [BEAT_W-1:0]    beat_data,
  output logic                 beat_last,
  input  logic                 beat_ready,
  output logic                 done
);
  logic                 active;
  logic                 lane;
  logic [DW_W-1:0]      stage_lo;
  logic [TLP_CNT_W-1:0] remaining;
  logic                 take;
  logic                 final_dw;

  assign pay_ready = active && (remaining != '0) && (!beat_valid || beat_ready);
  assign take      = pay_valid && pay_ready;
  assign final_dw  = (remaining == TLP_CNT_W'(1));
  assign done      = beat_valid && beat_ready && beat_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      active     <= 1'b0;
      lane       <= 1'b0;
      stage_lo   <= '0;
      remaining  <= '0;
      beat_valid <= 1'b0;
      beat_last  <= 1'b0;
      beat_data  <= '0;
    end else begin
      if (beat_valid && beat_ready) begin
        beat_valid <= 1'b0;
        beat_last  <= 1'b0;
      end
      if (start) begin
        active    <= 1'b1;
        lane      <= start_align;
        remaining <= start_count;
        stage_lo  <= '0;
      end else if (take) begin
        remaining <= remaining - TLP_CNT_W'(1);
        if (!lane && !final_dw) begin
          stage_lo <= pay_dw;
          lane     <= 1'b1;
        end else begin
          beat_valid <= 1'b1;
          beat_last  <= final_dw;
          beat_data  <= lane ? {pay_dw, stage_lo} : {{DW_W{1'b0}}, pay_dw};
          lane       <= 1'b0;
          stage_lo   <= '0;
        end
      end
      if (done) active <= 1'b0;
    end
  end

  // R11: a stalled beat keeps its contents
  p_beat_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && !beat_ready) |=>
      (beat_valid && $stable(beat_data) && $stable(beat_last)));

  // R5: beats appear only inside a started payload
  p_beat_in_packet_r5: assert property (@(posedge clk) disable iff (rst)
    beat_valid |-> active);
endmodule

// File: rtl/tlp_tx_driver.sv
module tlp_tx_driver
  import tlp_tx_pkg::*;
#(
  parameter int HDR_W = 128,
  parameter int DW_W  = 32,
  localparam int BEAT_W = 2 * DW_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pkt_valid,
  input  logic [HDR_W-1:0]  pkt_hdr,
  output logic              pkt_ready,
  input  logic              pay_valid,
  input  logic [DW_W-1:0]   pay_dw,
  output logic              pay_ready,
  output logic              hdr_req,
  output logic [HDR_W-1:0]  hdr_bus,
  input  logic              hdr_ack,
  output logic              beat_valid,
  output logic [BEAT_W-1:0] beat_data,
  output logic              beat_last,
  input  logic              beat_ready,
  output logic              busy
);
  // Header bit positions the decoder relies on
  localparam int FMT_DATA_BIT = 126;
  localparam int FMT_4DW_BIT  = 125;
  localparam int LEN_LSB      = 96;
  localparam int A2_4DW_BIT   = 2;
  localparam int A2_3DW_BIT   = 34;

  tx_state_e state;
  hdr_info_t in_info;
  hdr_info_t cur_info;
  logic      accept;
  logic      hdr_done;
  logic      pay_start;
  logic      pay_done;

  tlp_hdr_decode u_dec (
    .fmt_data  (pkt_hdr[FMT_DATA_BIT]),
    .fmt_4dw   (pkt_hdr[FMT_4DW_BIT]),
    .len_field (pkt_hdr[LEN_LSB +: TLP_LEN_W]),
    .addr2_4dw (pkt_hdr[A2_4DW_BIT]),
    .addr2_3dw (pkt_hdr[A2_3DW_BIT]),
    .info      (in_info)
  );

  assign hdr_done  = (state == ST_HDR) && hdr_ack;
  assign pkt_ready = (state == ST_IDLE) || (hdr_done && !cur_info.has_data);
  assign accept    = pkt_valid && pkt_ready;
  assign pay_start = hdr_done && cur_info.has_data;
  assign busy      = (state != ST_IDLE);

  tlp_hdr_stage #(.HDR_W(HDR_W)) u_hdr (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .load_hdr (pkt_hdr),
    .ack      (hdr_ack),
    .req      (hdr_req),
    .bus      (hdr_bus)
  );

  tlp_data_packer #(.DW_W(DW_W)) u_pack (
    .clk         (clk),
    .rst         (rst),
    .start       (pay_start),
    .start_align (cur_info.align_hi),
    .start_count (cur_info.dw_count),
    .pay_valid   (pay_valid),
    .pay_dw      (pay_dw),
    .pay_ready   (pay_ready),
    .beat_valid  (beat_valid),
    .beat_data   (beat_data),
    .beat_last   (beat_last),
    .beat_ready  (beat_ready),
    .done        (pay_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cur_info <= '0;
    end else begin
      if (accept) cur_info <= in_info;
      unique case (state)
        ST_IDLE: if (accept) state <= ST_HDR;
        ST_HDR:
          if (hdr_ack) begin
            if (cur_info.has_data) state <= ST_DATA;
            else if (!accept)      state <= ST_IDLE;
          end
        ST_DATA: if (pay_done) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R5: no beat while the header is outstanding
  p_no_beat_before_ack_r5: assert property (@(posedge clk) disable iff (rst)
    hdr_req |-> !beat_valid);

  // R12: an idle driver drives neither bus
  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!hdr_req && !beat_valid));
endmodule

// File: tb/tlp_tx_driver_test.sv
module tlp_tx_driver_test;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         pkt_valid = 1'b0;
  logic [127:0] pkt_hdr = '0;
  logic         pkt_ready;
  logic         pay_valid = 1'b0;
  logic [31:0]  pay_dw = '0;
  logic         pay_ready;
  logic         hdr_req;
  logic [127:0] hdr_bus;
  logic         hdr_ack = 1'b0;
  logic         beat_valid;
  logic [63:0]  beat_data;
  logic         beat_last;
  logic         beat_ready = 1'b0;
  logic         busy;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  tlp_tx_driver uut (
    .clk(clk), .rst(rst),
    .pkt_valid(pkt_valid), .pkt_hdr(pkt_hdr), .pkt_ready(pkt_ready),
    .pay_valid(pay_valid), .pay_dw(pay_dw), .pay_ready(pay_ready),
    .hdr_req(hdr_req), .hdr_bus(hdr_bus), .hdr_ack(hdr_ack),
    .beat_valid(beat_valid), .beat_data(beat_data), .beat_last(beat_last),
    .beat_ready(beat_ready), .busy(busy)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Header with a fixed filler; the ignored alignment bit is the opposite one
  function automatic logic [127:0] mk_hdr(input bit data, input bit four,
                                          input logic [9:0] len, input bit ahi);
    logic [127:0] h;
    h = 128'h1F2E_3D4C_5B6A_7988_97A6_B5C4_D3E2_F1F0;
    h[126] = data;
    h[125] = four;
    h[105:96] = len;
    if (four) begin h[2] = ahi; h[34] = ~ahi; end
    else      begin h[34] = ahi; h[2] = ~ahi; end
    return h;
  endfunction

  function automatic logic [31:0] dw_of(input int seed, input int i);
    return {seed[7:0], 24'(i)};
  endfunction

  // Sends one packet; ready_mask cycles the beat_ready pattern (bit k per cycle)
  task automatic send_pkt(input logic [127:0] h, input int seed,
                          input logic [3:0] ready_mask, input string tag);
    int n, a, last_k, k, sent, cyc;
    logic [63:0] exp_beat, held;
    bit was_stalled, fin;
    n = (h[105:96] == 0) ? 1024 : int'(h[105:96]);
    a = h[125] ? int'(h[2]) : int'(h[34]);
    @(negedge clk);
    pkt_valid = 1'b1; pkt_hdr = h;
    #1 chk(pkt_ready == 1'b1, {tag, " R2 pkt_ready"}, 128'(pkt_ready), 128'(1));
    @(negedge clk);
    pkt_valid = 1'b0;
    chk(hdr_req == 1'b1 && hdr_bus == h, {tag, " R2 header on bus"}, hdr_bus, h);
    chk(busy == 1'b1, {tag, " R12 busy"}, 128'(busy), 128'(1));
    @(negedge clk);
    chk(hdr_req == 1'b1 && hdr_bus == h, {tag, " R3 header held"}, hdr_bus, h);
    pay_valid = h[126];
    #1 chk(beat_valid == 1'b0 && pay_ready == 1'b0, {tag, " R5 nothing before ack"},
           128'({beat_valid, pay_ready}), 128'(0));
    hdr_ack = 1'b1;
    @(negedge clk);
    hdr_ack = 1'b0;
    if (!h[126]) begin
      chk(busy == 1'b0 && hdr_req == 1'b0, {tag, " R4 done at ack"},
          128'({busy, hdr_req}), 128'(0));
      return;
    end
    last_k = (a + n - 1) / 2;
    k = 0; sent = 0; was_stalled = 1'b0; fin = 1'b0; cyc = 0;
    while (!fin && cyc < 6000) begin
      if (was_stalled)
        chk(beat_valid == 1'b1 && beat_data == held, {tag, " R11 stalled beat held"},
            128'(beat_data), 128'(held));
      pay_dw = dw_of(seed, sent);
      beat_ready = ready_mask[cyc % 4];
      #1;
      if (beat_valid) begin
        exp_beat = '0;
        if (2*k >= a && 2*k - a < n) exp_beat[31:0] = dw_of(seed, 2*k - a);
        if (2*k + 1 - a < n)         exp_beat[63:32] = dw_of(seed, 2*k + 1 - a);
        chk(beat_data == exp_beat, {tag, " R9 R7 R8 R10 beat data"},
            128'(beat_data), 128'(exp_beat));
        chk(beat_last == (k == last_k), {tag, " R10 last flag"},
            128'(beat_last), 128'(k == last_k));
        if (beat_ready) begin
          k++;
          if (beat_last) fin = 1'b1;
        end
      end
      was_stalled = beat_valid && !beat_ready;
      held = beat_data;
      if (pay_valid && pay_ready) sent++;
      @(negedge clk);
      cyc++;
    end
    pay_valid = 1'b0; beat_ready = 1'b0;
    chk(k == last_k + 1 && sent == n, {tag, " R6 beat and DWORD count"},
        128'({32'(k), 32'(sent)}), 128'({32'(last_k + 1), 32'(n)}));
    chk(busy == 1'b0, {tag, " R12 busy drops"}, 128'(busy), 128'(0));
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1 chk(!hdr_req && !beat_valid && !beat_last && !busy && pkt_ready,
           "R1 reset state", 128'({hdr_req, beat_valid, beat_last, busy, pkt_ready}),
           128'(5'b00001));
  endtask

  task automatic t_back_to_back;
    logic [127:0] h1, h2;
    h1 = mk_hdr(1'b0, 1'b0, 10'd0, 1'b0);
    h2 = mk_hdr(1'b0, 1'b1, 10'd3, 1'b1) ^ 128'hFF;
    @(negedge clk);
    pkt_valid = 1'b1; pkt_hdr = h1;
    @(negedge clk);
    pkt_hdr = h2; hdr_ack = 1'b1;
    #1 chk(pkt_ready == 1'b1, "R4 ready in ack cycle", 128'(pkt_ready), 128'(1));
    @(negedge clk);
    pkt_valid = 1'b0; hdr_ack = 1'b0;
    chk(hdr_req == 1'b1 && hdr_bus == h2, "R4 second header next cycle", hdr_bus, h2);
    @(negedge clk);
    chk(hdr_req == 1'b1 && busy == 1'b1, "R3 second header held",
        128'({hdr_req, busy}), 128'(2'b11));
    hdr_ack = 1'b1;
    @(negedge clk);
    hdr_ack = 1'b0;
    chk(hdr_req == 1'b0 && busy == 1'b0, "R4 back to back done",
        128'({hdr_req, busy}), 128'(0));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    send_pkt(mk_hdr(1'b0, 1'b0, 10'd5, 1'b1), 1, 4'b1111, "nodata3");
    t_back_to_back();
    send_pkt(mk_hdr(1'b1, 1'b1, 10'd4, 1'b0), 2, 4'b1111, "4dw_lo_even");
    send_pkt(mk_hdr(1'b1, 1'b1, 10'd3, 1'b1), 3, 4'b1111, "4dw_hi_odd");
    send_pkt(mk_hdr(1'b1, 1'b0, 10'd1, 1'b1), 4, 4'b1111, "3dw_hi_single");
    send_pkt(mk_hdr(1'b1, 1'b0, 10'd5, 1'b0), 5, 4'b0101, "3dw_lo_stall");
    send_pkt(mk_hdr(1'b1, 1'b0, 10'd6, 1'b1), 6, 4'b0011, "3dw_hi_stall");
    send_pkt(mk_hdr(1'b1, 1'b1, 10'd0, 1'b0), 7, 4'b1111, "len0_1024");
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule